// File: doc/BRIEF.md
# Preemptive DMA Channel Arbiter

This block decides which of six DMA channels owns a single shared word-transfer datapath. Each channel raises `req` when it has a burst to move. The datapath pulses `word_done` as each word finishes and, in the same cycle, reports through `burst_act` whether the owning channel still has words left in its burst. Grants are registered and one-hot. The grant moves only from an idle datapath or at a word boundary, and in round-robin mode a channel keeps the bus until its burst is finished.

When `pri_mode` is set, channel 0 is the priority channel. It wins every burst boundary at which it requests. If it requests while another channel is in the middle of a burst, it takes the bus at the next word boundary. The interrupted channel is parked and shown on `suspended`. Channel 0 then runs its whole burst, and the parked channel gets the bus back before any other requester. The mode in force for a burst is captured when that burst starts, so toggling `pri_mode` mid-burst changes nothing until the next burst boundary.

The controller has three states:
- `ARB_IDLE`: nothing is granted.
- `ARB_BURST`: an ordinary burst owns the bus.
- `ARB_HIPRI`: channel 0 has preempted a parked channel.

It has six transitions:
- START: `ARB_IDLE` to `ARB_BURST` when a winner is found.
- CONTINUE: stay in the current state on a word with more to come.
- PREEMPT: `ARB_BURST` to `ARB_HIPRI`.
- HANDOFF: at a burst end, `ARB_BURST` grants the next winner.
- DRAIN: `ARB_BURST` to `ARB_IDLE` at a burst end with no requester.
- RESUME: `ARB_HIPRI` to `ARB_BURST`, giving the bus back to the parked channel.

Top module: `dma_chan_arbiter`

## Requirements
- R1: `grant` is one-hot or zero, and `suspended` is zero after reset. While `grant` is zero and no `req` bit is set, `grant` stays zero.
- R2: From an all-zero grant, a requesting channel is granted at the next clock edge. A granted channel keeps the grant through every `word_done` at which its own `burst_act` bit is 1.
- R3: A non-zero `grant` changes only at a clock edge where `word_done` was high in the preceding cycle.
- R4: Round-robin order applies at a burst end (`word_done` high with the owner's `burst_act` bit 0). The next grant goes to the first requesting channel in ascending cyclic order after the finishing channel, and the finishing channel is considered last. From idle, the search starts after the channel whose burst ended most recently. After reset, that search starts at channel 0.
- R5: In priority mode, suppose `word_done` arrives with the owner k≠0 still mid-burst and `req[0]` high. Then bit 0 of `grant` is set at the next edge, and bit k of `suspended` is set.
- R6: While a channel is parked, channel 0 keeps the grant until a `word_done` with `burst_act[0]`=0. At the next edge the parked channel is granted again, ahead of other requesters, and `suspended` returns to zero.
- R7: In priority mode, channel 0 wins every burst boundary (start from idle or burst end) at which it requests, regardless of the round-robin position.
- R8: `pri_mode` is captured only when a burst starts. Changing it during a burst neither enables nor disables preemption of that burst.
- R9: A `word_done` pulse while `grant` is zero has no effect on `grant`.
- R10: In round-robin mode, a request from channel 0 never interrupts another channel's burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 6 | Per-channel burst request |
| burst_act | input | 6 | Per-channel flag, sampled with `word_done`: 1 = more words remain in the burst |
| word_done | input | 1 | The granted channel's current word has completed |
| pri_mode | input | 1 | 1 = channel 0 preempts; 0 = plain round-robin |
| grant | output | 6 | One-hot owner of the datapath, zero when idle |
| suspended | output | 6 | One-hot channel parked by a preemption, zero otherwise |

## Verification
The bench drives several kinds of input pattern:
- Two or three channels requesting together in round-robin mode. This separates a rotating pointer from a fixed priority, and a burst-long hold from per-word switching.
- Wrap-around requests, which show whether the finisher is correctly placed last.
- Channel 0 requesting mid-burst, first in round-robin mode and then in priority mode. This tells preemption apart from an ordinary handoff and shows whether the parked channel is resumed ahead of a third requester.
- `pri_mode` toggled in the middle of a burst, which checks that the mode is captured only at burst starts.

A long random phase is then compared every cycle against a behavioural reference.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_BURST = 2'd1,
        ARB_HIPRI = 2'd2
    } arb_state_e;

endpackage

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
    parameter int NUM_CH = 6,
    parameter int IW     = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [IW-1:0]     base,
    input  logic              hi_first,
    output logic              found,
    output logic [IW-1:0]     pick
);

    int idx;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        idx   = 0;
        if (hi_first && req[0]) begin
            found = 1'b1;
            pick  = '0;
        end else begin
            for (int k = 1; k <= NUM_CH; k++) begin
                idx = (int'(base) + k) % NUM_CH;
                if (!found && req[idx]) begin
                    found = 1'b1;
                    pick  = idx[IW-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/dma_arb_park.sv
module dma_arb_park #(
    parameter int NUM_CH = 6,
    parameter int IW     = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park_en,
    input  logic [IW-1:0]     park_idx,
    input  logic              unpark,
    output logic              valid,
    output logic [IW-1:0]     idx,
    output logic [NUM_CH-1:0] onehot
);

    logic          valid_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else if (park_en) begin
            valid_q <= 1'b1;
            idx_q   <= park_idx;
        end else if (unpark) begin
            valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign idx   = idx_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        assign onehot[i] = valid_q && (idx_q == IW'(i));
    end

    // R5: only a non-priority channel is parked, and only into an empty slot
    assert_park_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        park_en |-> (!valid_q && park_idx != '0));

    // R6: unparking only happens while something is parked
    assert_unpark_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unpark |-> valid_q);

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] burst_act,
    input  logic              word_done,
    input  logic              pri_mode,
    output logic [NUM_CH-1:0] grant,
    output logic [NUM_CH-1:0] suspended
);

    localparam int IW = $clog2(NUM_CH);

    arb_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;
    logic [IW-1:0] last_q, last_d;
    logic          mode_q, mode_d;

    logic          park_en, unpark, park_valid;
    logic [IW-1:0] park_idx;
    logic [IW-1:0] search_base;
    logic          win_found;
    logic [IW-1:0] win_idx;
    logic          owner_more;

    assign search_base = (state_q == ARB_IDLE) ? last_q : owner_q;
    assign owner_more  = burst_act[owner_q];

    dma_arb_rr_pick #(.NUM_CH(NUM_CH), .IW(IW)) u_pick (
        .req      (req),
        .base     (search_base),
        .hi_first (pri_mode),
        .found    (win_found),
        .pick     (win_idx)
    );

    dma_arb_park #(.NUM_CH(NUM_CH), .IW(IW)) u_park (
        .clk      (clk),
        .rst_n    (rst_n),
        .park_en  (park_en),
        .park_idx (owner_q),
        .unpark   (unpark),
        .valid    (park_valid),
        .idx      (park_idx),
        .onehot   (suspended)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
            last_q  <= IW'(NUM_CH - 1);
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            last_q  <= last_d;
            mode_q  <= mode_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        last_d  = last_q;
        mode_d  = mode_q;
        park_en = 1'b0;
        unpark  = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (win_found) begin            // START
                    state_d = ARB_BURST;
                    owner_d = win_idx;
                    mode_d  = pri_mode;
                end
            end
            ARB_BURST: begin
                if (word_done) begin
                    if (owner_more) begin
                        if (mode_q && owner_q != '0 && req[0]) begin  // PREEMPT
                            state_d = ARB_HIPRI;
                            owner_d = '0;
                            park_en = 1'b1;
                        end
                    end else begin
                        last_d = owner_q;
                        if (win_found) begin    // HANDOFF
                            owner_d = win_idx;
                            mode_d  = pri_mode;
                        end else begin          // DRAIN
                            state_d = ARB_IDLE;
                        end
                    end
                end
            end
            ARB_HIPRI: begin
                if (word_done && !owner_more) begin  // RESUME
                    state_d = ARB_BURST;
                    last_d  = '0;
                    owner_d = park_idx;
                    unpark  = 1'b1;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        grant = '0;
        if (state_q != ARB_IDLE) grant[owner_q] = 1'b1;
    end

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req == '0) |=> grant == '0);

    assert_grant_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !word_done) |=> $stable(grant));

    assert_park_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended != '0) |-> (grant[0] && $onehot(suspended) && (grant & suspended) == '0));

    assert_park_at_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|suspended) |-> $past(word_done));

    assert_rr_no_preempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_BURST && !mode_q) |=> !park_valid);

endmodule

// File: tb/sim_dma_chan_arbiter.sv
module sim_dma_chan_arbiter;

    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] req = '0;
    logic [NCH-1:0] bact = '0;
    logic           wdone = 1'b0;
    logic           pmode = 1'b0;
    logic [NCH-1:0] grant;
    logic [NCH-1:0] susp;

    always #4ns clk = ~clk;

    dma_chan_arbiter #(.NUM_CH(NCH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .burst_act (bact),
        .word_done (wdone),
        .pri_mode  (pmode),
        .grant     (grant),
        .suspended (susp)
    );

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    // behavioural reference
    int m_own  = -1;
    int m_last = NCH - 1;
    int m_park = -1;
    bit m_mode = 1'b0;

    function automatic int choose(bit pm);
        if (pm && req[0]) return 0;
        for (int k = 1; k <= NCH; k++) begin
            int i = (m_last + k) % NCH;
            if (req[i]) return i;
        end
        return -1;
    endfunction

    task automatic model_step();
        int w;
        if (m_own < 0) begin
            w = choose(pmode);
            if (w >= 0) begin m_own = w; m_mode = pmode; end
        end else if (m_park >= 0) begin
            if (wdone && !bact[0]) begin
                m_last = 0; m_own = m_park; m_park = -1;
            end
        end else if (wdone) begin
            if (bact[m_own]) begin
                if (m_mode && m_own != 0 && req[0]) begin
                    m_park = m_own; m_own = 0;
                end
            end else begin
                m_last = m_own;
                w = choose(pmode);
                if (w >= 0) begin m_own = w; m_mode = pmode; end
                else m_own = -1;
            end
        end
    endtask

    function automatic logic [NCH-1:0] exp_grant();
        return (m_own < 0) ? '0 : (NCH'(1) << m_own);
    endfunction

    function automatic logic [NCH-1:0] exp_susp();
        return (m_park < 0) ? '0 : (NCH'(1) << m_park);
    endfunction

    task automatic cyc();
        model_step();
        @(posedge clk);
        #2ns;
        vecs++;
        if (grant !== exp_grant() || susp !== exp_susp()) begin
            errs++;
            $display("FAIL per-cycle model R4: grant=%b susp=%b expected grant=%b susp=%b",
                     grant, susp, exp_grant(), exp_susp());
        end
    endtask

    task automatic drive(logic [NCH-1:0] r, logic [NCH-1:0] b, logic w, logic p);
        req = r; bact = b; wdone = w; pmode = p;
    endtask

    task automatic chk(logic [NCH-1:0] eg, logic [NCH-1:0] es, string tag);
        vecs++;
        if (grant !== eg || susp !== es) begin
            errs++;
            $display("FAIL %s: grant=%b susp=%b expected grant=%b susp=%b",
                     tag, grant, susp, eg, es);
        end
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2ns rst_n = 1'b1;
        chk(6'b000000, 6'b000000, "R1 reset");

        // idle, stray word_done
        drive(6'b000000, 6'b000000, 1'b0, 1'b0); cyc(); chk(6'b000000, 6'b000000, "R1 idle");
        drive(6'b000000, 6'b111111, 1'b1, 1'b0); cyc(); chk(6'b000000, 6'b000000, "R9 stray word_done");

        // round-robin among channels 1 and 2
        drive(6'b000110, 6'b000000, 1'b0, 1'b0); cyc(); chk(6'b000010, 6'b000000, "R2 start");
        drive(6'b000110, 6'b111111, 1'b0, 1'b0); cyc(); cyc(); chk(6'b000010, 6'b000000, "R3 hold");
        drive(6'b000110, 6'b111111, 1'b1, 1'b0); cyc(); chk(6'b000010, 6'b000000, "R2 mid-burst");
        drive(6'b000110, 6'b000000, 1'b1, 1'b0); cyc(); chk(6'b000100, 6'b000000, "R4 rotate");
        drive(6'b000110, 6'b000000, 1'b1, 1'b0); cyc(); chk(6'b000010, 6'b000000, "R4 wrap");
        drive(6'b000000, 6'b000000, 1'b1, 1'b0); cyc(); chk(6'b000000, 6'b000000, "R1 drain");

        // round-robin: channel 0 must not preempt
        drive(6'b000100, 6'b000000, 1'b0, 1'b0); cyc(); chk(6'b000100, 6'b000000, "R4 from idle");
        drive(6'b000101, 6'b111111, 1'b1, 1'b0); cyc(); chk(6'b000100, 6'b000000, "R10 no preempt");
        drive(6'b000001, 6'b000000, 1'b1, 1'b0); cyc(); chk(6'b000001, 6'b000000, "R4 handoff");
        drive(6'b000000, 6'b000000, 1'b1, 1'b0); cyc(); chk(6'b000000, 6'b000000, "R1 drain");

        // priority mode: preempt and resume
        drive(6'b001000, 6'b000000, 1'b0, 1'b1); cyc(); chk(6'b001000, 6'b000000, "R4 start ch3");
        drive(6'b001001, 6'b111111, 1'b1, 1'b1); cyc(); chk(6'b000001, 6'b001000, "R5 preempt");
        drive(6'b001001, 6'b111111, 1'b0, 1'b1); cyc(); chk(6'b000001, 6'b001000, "R6 hold");
        drive(6'b001011, 6'b111111, 1'b1, 1'b1); cyc(); chk(6'b000001, 6'b001000, "R6 burst");
        drive(6'b001011, 6'b111110, 1'b1, 1'b1); cyc(); chk(6'b001000, 6'b000000, "R6 resume");
        drive(6'b000011, 6'b000000, 1'b1, 1'b1); cyc(); chk(6'b000001, 6'b000000, "R7 boundary win");
        drive(6'b000010, 6'b000000, 1'b1, 1'b1); cyc(); chk(6'b000010, 6'b000000, "R4 after ch0");

        // mode captured at burst start
        drive(6'b000011, 6'b111111, 1'b1, 1'b0); cyc(); chk(6'b000001, 6'b000010, "R8 captured on");
        drive(6'b000010, 6'b000000, 1'b1, 1'b0); cyc(); chk(6'b000010, 6'b000000, "R6 resume");
        drive(6'b000100, 6'b000000, 1'b1, 1'b0); cyc(); chk(6'b000100, 6'b000000, "R4 next");
        drive(6'b000101, 6'b111111, 1'b1, 1'b1); cyc(); chk(6'b000100, 6'b000000, "R8 captured off");
        drive(6'b000000, 6'b000000, 1'b1, 1'b1); cyc(); chk(6'b000000, 6'b000000, "R1 drain");

        // random phase against the reference
        for (int n = 0; n < 4000; n++) begin
            logic p;
            p = (n % 300 < 150);
            if (n % 7 == 3) p = ~p;
            drive(NCH'($urandom), NCH'($urandom | $urandom), 1'($urandom), p);
            cyc();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule